// File: doc/BRIEF.md
# Keypad debounce and multi-key lockout controller

This block sits behind a row-scanning keypad scanner. It turns the scanner's raw, cycle-by-cycle view of the matrix into two stable outputs: a registered key code and a key-pressed flag. The raw inputs are a detect flag and the code of the key under the active row. At the end of each full scan the scanner also reports whether any key was seen in that frame.

When the raw detect appears, the controller asks the scanner to freeze on the current row. It then confirms the same code at a fixed number of check ticks before it accepts the key. After acceptance the freeze is lifted. The controller stops looking at the raw detect and code and watches only the frame summaries. The flag drops only after every completed frame has reported an empty matrix for a full clear interval. Only then can another key be taken. Contact bounce on press or on release therefore never reaches the outputs. Any key pressed while an accepted key is held is locked out.

Top module: `keypad_accept_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears `key_value` to 0, `key_pressed` to 0 and `scan_hold` to 0, and leaves the controller waiting for a press.
- R2: `key_value` is the raw code (key index 0..15) that was captured. This happens on the clock edge CONFIRMS×CHECK_CYC edges after the edge that first sampled `raw_hit`. It requires that `raw_hit` stayed high and the code matched at every check tick. With the default parameters at 50 MHz this takes 1 ms.
- R3: For an accepted key, `key_value` holds its new code for exactly one cycle before `key_pressed` rises.
- R4: `key_value` keeps the last accepted code after release and while `key_pressed` is low, until the next acceptance or reset.
- R5: If `raw_hit` falls during confirmation, the confirmation is abandoned and neither output changes.
- R6: If the code differs from the captured one at a check tick, confirmation restarts with the new code. Keys that go down within one confirmation window give a single `key_pressed` rise, and the code belongs to one of them.
- R7: `scan_hold` is high from the cycle after `raw_hit` is first seen until acceptance or abandonment, and low otherwise.
- R8: While `key_pressed` is high, `raw_hit` and `raw_code` have no effect. This holds even when the accepted key is released and a later key stays down: the value and flag are unchanged.
- R9: `key_pressed` falls only after the frame summaries report an empty matrix continuously for at least CLEAR_CYC cycles. A frame that reports a key during that span restarts it.
- R10: After a debounced full release, a new press is accepted again under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_hit | input | 1 | Raw detect from the scanner for the current row |
| raw_code | input | CODE_W | Raw code of the detected key |
| frame_done | input | 1 | One-cycle pulse at the end of a full scan |
| frame_any | input | 1 | Any key seen in the frame that is ending (valid with frame_done) |
| key_value | output | CODE_W | Last accepted key code |
| key_pressed | output | 1 | High while an accepted key is held |
| scan_hold | output | 1 | Request to the scanner to stay on the current row |

## Verification
A wrong internal state shows up at the ports within a known number of cycles. A confirmation counter that is off by one moves the `key_pressed` rise away from its exact cycle, CONFIRMS×CHECK_CYC+1 edges after detection. A missed abort leaks a bounce burst onto `key_value` within one check window. If the controller returns to the waiting state too early, lockout breaks: a second held key replaces the value as soon as the first key is released. If the clear span is counted wrongly, the flag falls before CLEAR_CYC cycles, or later than two frames after it. The sweep covers all 16 codes, bounce bursts of every length shorter than the window, staggered and simultaneous presses, and release bounce.

// File: rtl/kac_pkg.sv
package kac_pkg;
  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_ARM   = 2'd1,
    KS_HELD  = 2'd2,
    KS_CLEAR = 2'd3
  } kac_state_e;
endpackage

// File: rtl/kac_span_timer.sv
// Cycle timer: either a wrapping tick generator or a saturating span counter.
module kac_span_timer #(
  parameter int LIMIT    = 4,
  parameter bit SATURATE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  generate
    if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
        if (rst || clear)                   cnt <= '0;
        else if (run && cnt != CW'(LIMIT))  cnt <= cnt + 1'b1;
      end
      assign done = (cnt == CW'(LIMIT));
    end else begin : g_wrap
      always_ff @(posedge clk) begin
        if (rst || clear || (run && cnt == CW'(LIMIT - 1))) cnt <= '0;
        else if (run)                                       cnt <= cnt + 1'b1;
      end
      assign done = run && (cnt == CW'(LIMIT - 1));
    end
  endgenerate
endmodule

// File: rtl/kac_fsm.sv
// Press confirmation, lockout and release tracking.
module kac_fsm
  import kac_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int CONFIRMS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_hit,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              frame_done,
  input  logic              frame_any,
  input  logic              chk_tick,
  input  logic              clr_done,
  output kac_state_e        st,
  output logic [CODE_W-1:0] cand,
  output logic              accept
);
  localparam int NW = $clog2(CONFIRMS + 1);

  kac_state_e  st_nx;
  logic [NW-1:0] conf;
  logic        match, last;

  assign match = (raw_code == cand);
  assign last  = (conf == NW'(CONFIRMS - 1));

  always_comb begin
    st_nx  = st;
    accept = 1'b0;
    case (st)
      KS_IDLE: if (raw_hit) st_nx = KS_ARM;
      KS_ARM: begin
        if (!raw_hit) st_nx = KS_IDLE;
        else if (chk_tick) begin
          if (!match) st_nx = KS_IDLE;
          else if (last) begin
            st_nx  = KS_HELD;
            accept = 1'b1;
          end
        end
      end
      KS_HELD: if (frame_done && !frame_any) st_nx = KS_CLEAR;
      KS_CLEAR: begin
        if (frame_done) begin
          if (frame_any)     st_nx = KS_HELD;
          else if (clr_done) st_nx = KS_IDLE;
        end
      end
      default: st_nx = KS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= KS_IDLE;
      cand <= '0;
      conf <= '0;
    end else begin
      st <= st_nx;
      if (st == KS_IDLE) begin
        cand <= raw_code;
        conf <= '0;
      end else if (st == KS_ARM && raw_hit && chk_tick && match && !last) begin
        conf <= conf + 1'b1;
      end
    end
  end

  // R5: a dropped detect during confirmation returns to waiting
  a_r5_drop_aborts: assert property (@(posedge clk) disable iff (rst)
    (st == KS_ARM && !raw_hit) |=> (st == KS_IDLE));

  // R2: acceptance only with detect present and the captured code matching
  a_r2_accept_needs_match: assert property (@(posedge clk) disable iff (rst)
    ($past(st == KS_ARM) && st == KS_HELD) |-> $past(raw_hit && raw_code == cand));

  // R9: return to waiting only on a clear frame after the full span
  a_r9_leave_on_clear_frame: assert property (@(posedge clk) disable iff (rst)
    ($past(st == KS_CLEAR) && st == KS_IDLE) |-> $past(frame_done && !frame_any && clr_done));
endmodule

// File: rtl/keypad_accept_ctrl.sv
module keypad_accept_ctrl
  import kac_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int CHECK_CYC = 25000,
  parameter int CONFIRMS  = 2,
  parameter int CLEAR_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_hit,
  input  logic [CODE_W-1:0] raw_code,
  input  logic              frame_done,
  input  logic              frame_any,
  output logic [CODE_W-1:0] key_value,
  output logic              key_pressed,
  output logic              scan_hold
);
  kac_state_e        st;
  logic [CODE_W-1:0] cand;
  logic              accept, chk_tick, clr_done;

  kac_span_timer #(.LIMIT(CHECK_CYC), .SATURATE(1'b0)) u_check (
    .clk(clk), .rst(rst), .clear(st != KS_ARM), .run(st == KS_ARM), .done(chk_tick)
  );

  kac_span_timer #(.LIMIT(CLEAR_CYC), .SATURATE(1'b1)) u_clear (
    .clk(clk), .rst(rst), .clear(st != KS_CLEAR), .run(st == KS_CLEAR), .done(clr_done)
  );

  kac_fsm #(.CODE_W(CODE_W), .CONFIRMS(CONFIRMS)) u_fsm (
    .clk(clk), .rst(rst), .raw_hit(raw_hit), .raw_code(raw_code),
    .frame_done(frame_done), .frame_any(frame_any),
    .chk_tick(chk_tick), .clr_done(clr_done),
    .st(st), .cand(cand), .accept(accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_value   <= '0;
      key_pressed <= 1'b0;
    end else begin
      if (accept) key_value <= cand;
      key_pressed <= (st == KS_HELD) || (st == KS_CLEAR);
    end
  end

  assign scan_hold = (st == KS_ARM);

  // R1: reset clears both outputs and the hold request
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (key_value == '0 && !key_pressed && !scan_hold));

  // R3: the code is already settled when the flag rises
  a_r3_value_before_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(key_pressed) |-> $stable(key_value));

  // R4: the code moves only out of a confirmation with detect present
  a_r4_value_moves_on_accept: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_value) |-> $past(st == KS_ARM && raw_hit));

  // R8: lockout keeps the code while the flag stays high
  a_r8_lockout_value: assert property (@(posedge clk) disable iff (rst)
    (key_pressed && $past(key_pressed)) |-> $stable(key_value));

  // R9: the flag falls only after a frame that reported an empty matrix
  a_r9_fall_after_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(key_pressed) |-> $past(frame_done && !frame_any, 2));
endmodule

// File: tb/sim_keypad_accept_ctrl.sv
module sim_keypad_accept_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CHK   = 4;
  localparam int CONF  = 2;
  localparam int CLR   = 20;
  localparam int FRAME = 8;
  localparam int WD    = 100000;
  localparam int PRESS_N = CONF * CHK + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] keys = '0;
  logic [2:0]  fcnt = '0;
  logic [3:0]  raw_code;
  logic        raw_hit, frame_done, frame_any;
  logic [3:0]  key_value;
  logic        key_pressed, scan_hold;

  int checks = 0;
  int errors = 0;
  int rises  = 0;
  logic kp_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // scanner model: lowest pressed index wins, frames every FRAME cycles
  always_comb begin
    raw_code = '0;
    for (int i = 15; i >= 0; i--) if (keys[i]) raw_code = 4'(i);
  end
  assign raw_hit    = |keys;
  assign frame_any  = |keys;
  assign frame_done = (fcnt == 3'(FRAME - 1));
  always @(negedge clk) fcnt <= fcnt + 1'b1;

  always @(negedge clk) begin
    if (key_pressed && !kp_prev) rises++;
    kp_prev <= key_pressed;
  end

  keypad_accept_ctrl #(.CODE_W(4), .CHECK_CYC(CHK), .CONFIRMS(CONF), .CLEAR_CYC(CLR)) u0 (
    .clk(clk), .rst(rst), .raw_hit(raw_hit), .raw_code(raw_code),
    .frame_done(frame_done), .frame_any(frame_any),
    .key_value(key_value), .key_pressed(key_pressed), .scan_hold(scan_hold)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // press key k cleanly and check exact acceptance timing
  task automatic press_measure(input int k);
    logic pv_kp;
    logic [3:0] pv_val;
    int found;
    pv_kp = key_pressed;
    pv_val = key_value;
    found = 0;
    keys = 16'(1) << k;
    for (int n = 1; n <= 40 && found == 0; n++) begin
      @(negedge clk);
      if (n == 1) chk(scan_hold == 1'b1, "R7 hold during confirm", int'(scan_hold), 1);
      if (key_pressed) begin
        found = n;
        chk(n == PRESS_N, "R2 accept latency", n, PRESS_N);
        chk(key_value == 4'(k), "R2 accepted code", int'(key_value), k);
        chk(!pv_kp && pv_val == 4'(k), "R3 value one cycle before flag", int'(pv_val), k);
        chk(scan_hold == 1'b0, "R7 hold released", int'(scan_hold), 0);
      end
      pv_kp = key_pressed;
      pv_val = key_value;
    end
    if (found == 0) chk(1'b0, "R2 no acceptance", 0, 1);
  endtask

  // release everything and check the debounced fall and retained code
  task automatic release_measure(input int expv);
    int found;
    found = 0;
    keys = '0;
    for (int n = 1; n <= 200 && found == 0; n++) begin
      @(negedge clk);
      if (!key_pressed) begin
        found = n;
        chk(n > CLR && n <= CLR + 2 * FRAME + 3, "R9 release span", n, CLR + FRAME);
      end
    end
    if (found == 0) chk(1'b0, "R9 flag never fell", 0, 1);
    chk(key_value == 4'(expv), "R4 value kept after release", int'(key_value), expv);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD, 0);
    finish_run();
  end

  initial begin
    int r0;
    cyc(3);
    chk(key_value == 4'd0, "R1 reset value", int'(key_value), 0);
    chk(key_pressed == 1'b0, "R1 reset flag", int'(key_pressed), 0);
    chk(scan_hold == 1'b0, "R1 reset hold", int'(scan_hold), 0);
    rst = 1'b0;
    cyc(3);

    // full sweep of codes; each re-arm checks R10
    for (int k = 0; k < 16; k++) begin
      press_measure(k);
      release_measure(k);
      cyc(2);
    end
    chk(rises == 16, "R10 one rise per press", rises, 16);

    // R5: bounce bursts shorter than the confirmation window
    r0 = rises;
    for (int len = 1; len <= 2 * CHK; len++) begin
      keys = 16'(1) << 3;
      cyc(len);
      keys = '0;
      cyc(3);
      chk(!key_pressed && key_value == 4'd15, "R5 bounce ignored", int'(key_value), 15);
    end
    chk(rises == r0, "R5 no flag pulse", rises, r0);
    press_measure(3);
    release_measure(3);

    // R6: staggered press within the window, then simultaneous press
    r0 = rises;
    keys = 16'(1) << 9;
    cyc(6);
    keys = keys | (16'(1) << 2);
    cyc(40);
    chk(key_value == 4'd2, "R6 code after mismatch restart", int'(key_value), 2);
    chk(rises == r0 + 1, "R6 single indication staggered", rises, r0 + 1);
    release_measure(2);
    r0 = rises;
    keys = (16'(1) << 5) | (16'(1) << 12);
    cyc(40);
    chk(key_value == 4'd5 || key_value == 4'd12, "R6 simultaneous code", int'(key_value), 5);
    chk(rises == r0 + 1, "R6 single indication simultaneous", rises, r0 + 1);
    release_measure(int'(key_value));

    // R8: lockout, first key released while a later one stays down
    press_measure(6);
    keys = keys | (16'(1) << 10);
    cyc(30);
    keys = 16'(1) << 10;
    cyc(60);
    chk(key_pressed == 1'b1, "R8 flag held by later key", int'(key_pressed), 1);
    chk(key_value == 4'd6, "R8 later key ignored", int'(key_value), 6);
    release_measure(6);
    cyc(2);
    press_measure(10);

    // R9: release bounce restarts the clear span
    keys = '0;
    cyc(6);
    keys = 16'(1) << 10;
    cyc(12);
    chk(key_pressed == 1'b1, "R9 flag kept through release bounce", int'(key_pressed), 1);
    release_measure(10);

    // R1: reset while a key is accepted
    press_measure(7);
    rst = 1'b1;
    cyc(2);
    chk(key_value == 4'd0 && !key_pressed && !scan_hold, "R1 reset in use",
        int'(key_value), 0);
    keys = '0;
    rst = 1'b0;
    cyc(3);
    chk(!key_pressed, "R1 idle after reset", int'(key_pressed), 0);

    finish_run();
  end
endmodule